// File: doc/BRIEF.md
# Operand Offset Generator for ModRM/SIB Addressing

This block works out the memory operand offset of an x86-style instruction. A `start` pulse hands it the ModRM byte and the address size. Any SIB byte and displacement bytes then arrive one at a time over a valid/ready byte stream. A flattened snapshot of the eight general registers feeds the base and index terms.

When the offset is known, the block raises `done` for one cycle. With it come the offset, a flag that says the stack segment should be the default, and the number of addressing bytes consumed. A register-direct ModRM (mod = 3) is not a memory operand. For that form the block reports the selected register number and gives no offset. Segment selection and the memory access itself belong to the neighbouring logic.

Top module: `ea_gen`

## Requirements
- R1: The ModRM byte is decoded as mod = bits 7:6 and rm = bits 2:0. When mod = 3, `done` rises one cycle after `start`. In that cycle `is_reg` = 1, `reg_sel` = rm, `ea` = 0 and `length` = 1.
- R2: The register snapshot holds slot i at bits [32i+31:32i], in the order EAX, ECX, EDX, EBX, ESP, EBP, ESI, EDI. In 16-bit mode the low 16 bits of these are used, and rm 0..7 selects BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX.
- R3: In 16-bit mode, mod = 1 adds a sign-extended 8-bit displacement and mod = 2 adds a 16-bit displacement. mod = 0 with rm = 6 uses a 16-bit direct displacement and no register. The result wraps at 16 bits, and `ea[31:16]` is 0.
- R4: In 16-bit mode, `stack_dflt` is 1 exactly when the form uses BP: rm 2 or 3, or rm 6 with mod 1 or 2.
- R5: In 32-bit mode without a SIB byte, the offset is register[rm] plus the displacement: none for mod 0, a sign-extended 8-bit value for mod 1, 32 bits for mod 2. mod = 0 with rm = 5 takes a 32-bit absolute displacement. rm = 5 with mod 1 or 2 uses EBP and sets `stack_dflt`.
- R6: In 32-bit mode, rm = 4 makes the first stream byte a SIB byte, with scale = bits 7:6, index = bits 5:3 and base = bits 2:0. The offset is base + index×(1<<scale) + displacement, and an index of 4 contributes 0.
- R7: A SIB base of 5 with mod = 0 takes a 32-bit displacement instead of EBP. A SIB base of 4 (ESP) sets `stack_dflt`, and so does a SIB base of 5 with mod 1 or 2.
- R8: A stream byte is taken at each clock edge where `byte_valid` and `byte_ready` are both 1. Displacement bytes arrive least significant first. `byte_ready` is 1 only while a byte is still owed, and gaps in `byte_valid` only delay the result.
- R9: `done` is a one-cycle pulse that comes one cycle after the last byte is taken, or one cycle after `start` if no byte is owed.
- R10: `length` = 1 + (1 if a SIB byte was used) + the number of displacement bytes.
- R11: `start` has no effect unless the block is idle, and `byte_valid` has no effect while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a decode with `modrm` and `addr32` |
| addr32 | input | 1 | 1 = 32-bit address size, 0 = 16-bit |
| modrm | input | 8 | ModRM byte |
| regs | input | 256 | Register snapshot, 8 × 32 bits |
| byte_valid | input | 1 | Stream byte present |
| byte_data | input | 8 | Stream byte (SIB, then displacement) |
| byte_ready | output | 1 | Block accepts a stream byte |
| done | output | 1 | Result valid for this cycle |
| ea | output | 32 | Effective offset |
| stack_dflt | output | 1 | Stack segment is the default |
| is_reg | output | 1 | Operand is a register |
| reg_sel | output | 3 | Register number when `is_reg` |
| length | output | 3 | Addressing bytes consumed |

## Verification
Two pairs of events can fall in the same cycle. A new `start` can arrive while a displacement byte is being taken. The bench provokes this by pulsing `start` with a register-direct ModRM and the opposite address size together with the second displacement byte. It then judges that the offset, flag and length still match the first instruction. The second pair is a `byte_valid` pulse while the block is idle. The bench drives `byte_valid` high with no decode in progress and expects neither `byte_ready` nor `done` to rise. A later decode must still produce correct results.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int XW = 32,
  parameter int NR = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             addr32,
  input  logic [7:0]       modrm,
  input  logic [NR*XW-1:0] regs,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  output logic             byte_ready,
  output logic             done,
  output logic [XW-1:0]    ea,
  output logic             stack_dflt,
  output logic             is_reg,
  output logic [2:0]       reg_sel,
  output logic [2:0]       length
);
  typedef enum logic [1:0] {S_IDLE, S_SIB, S_DISP, S_DONE} st_t;

  st_t         st;
  logic [1:0]  mod_q;
  logic [2:0]  rm_q;
  logic        a32_q;
  logic [7:0]  sib_q;
  logic [31:0] disp_q;
  logic [2:0]  cnt_q, dlen_q;

  function automatic logic [2:0] disp_len(input logic w32, input logic [1:0] md, input logic [2:0] fld);
    if (md == 2'd1) return 3'd1;
    if (md == 2'd2) return w32 ? 3'd4 : 3'd2;
    if (w32) return (fld == 3'd5) ? 3'd4 : 3'd0;
    return (fld == 3'd6) ? 3'd2 : 3'd0;
  endfunction

  function automatic logic [XW-1:0] rd(input logic [2:0] i);
    return regs[XW*int'(i) +: XW];
  endfunction

  logic has_sib;
  assign has_sib    = a32_q && rm_q == 3'd4 && mod_q != 2'd3;
  assign byte_ready = (st == S_SIB) || (st == S_DISP);
  assign done       = (st == S_DONE);
  assign is_reg     = (mod_q == 2'd3);
  assign reg_sel    = rm_q;
  assign length     = 3'd1 + {2'b0, has_sib} + dlen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; mod_q <= '0; rm_q <= '0; a32_q <= 1'b0;
      sib_q <= '0; disp_q <= '0; cnt_q <= '0; dlen_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          mod_q  <= modrm[7:6];
          rm_q   <= modrm[2:0];
          a32_q  <= addr32;
          sib_q  <= '0;
          disp_q <= '0;
          cnt_q  <= '0;
          if (modrm[7:6] == 2'd3) begin
            dlen_q <= '0;
            st     <= S_DONE;
          end else if (addr32 && modrm[2:0] == 3'd4) begin
            dlen_q <= '0;
            st     <= S_SIB;
          end else begin
            dlen_q <= disp_len(addr32, modrm[7:6], modrm[2:0]);
            st     <= (disp_len(addr32, modrm[7:6], modrm[2:0]) == 3'd0) ? S_DONE : S_DISP;
          end
        end
        S_SIB: if (byte_valid) begin
          sib_q  <= byte_data;
          dlen_q <= disp_len(1'b1, mod_q, byte_data[2:0]);
          st     <= (disp_len(1'b1, mod_q, byte_data[2:0]) == 3'd0) ? S_DONE : S_DISP;
        end
        S_DISP: if (byte_valid) begin
          disp_q[{cnt_q[1:0], 3'b000} +: 8] <= byte_data;
          cnt_q <= cnt_q + 3'd1;
          if (cnt_q + 3'd1 == dlen_q) st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [31:0] dext;
  assign dext = (dlen_q == 3'd1) ? {{24{disp_q[7]}}, disp_q[7:0]} : disp_q;

  logic [15:0] b16, i16;
  logic        stk16;
  always_comb begin
    b16 = '0; i16 = '0;
    case (rm_q)
      3'd0: begin b16 = rd(3'd3)[15:0]; i16 = rd(3'd6)[15:0]; end
      3'd1: begin b16 = rd(3'd3)[15:0]; i16 = rd(3'd7)[15:0]; end
      3'd2: begin b16 = rd(3'd5)[15:0]; i16 = rd(3'd6)[15:0]; end
      3'd3: begin b16 = rd(3'd5)[15:0]; i16 = rd(3'd7)[15:0]; end
      3'd4: b16 = rd(3'd6)[15:0];
      3'd5: b16 = rd(3'd7)[15:0];
      3'd6: b16 = (mod_q == 2'd0) ? 16'd0 : rd(3'd5)[15:0];
      default: b16 = rd(3'd3)[15:0];
    endcase
  end
  assign stk16 = (rm_q == 3'd2) || (rm_q == 3'd3) || (rm_q == 3'd6 && mod_q != 2'd0);

  logic [2:0]    bsel, isel;
  logic          nobase;
  logic [XW-1:0] b32, i32;
  assign bsel   = has_sib ? sib_q[2:0] : rm_q;
  assign isel   = sib_q[5:3];
  assign nobase = (mod_q == 2'd0) && (bsel == 3'd5);
  assign b32    = nobase ? '0 : rd(bsel);
  assign i32    = (has_sib && isel != 3'd4) ? (rd(isel) << sib_q[7:6]) : '0;

  logic [15:0] sum16;
  assign sum16 = b16 + i16 + dext[15:0];

  assign ea         = is_reg ? '0 : (a32_q ? (b32 + i32 + dext) : {16'd0, sum16});
  assign stack_dflt = !is_reg && (a32_q ? (!nobase && (bsel == 3'd4 || bsel == 3'd5)) : stk16);

  assert_done_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_reg_form_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && modrm[7:6] == 2'd3) |=> (done && is_reg && length == 3'd1 && ea == '0));
  assert_len_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (length >= 3'd1 && length <= 3'd6));
  assert_trunc16_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !a32_q) |-> (ea[XW-1:16] == '0));
  assert_ready_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> !done);
  assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && start) |=> ($stable(rm_q) && $stable(mod_q) && $stable(a32_q)));
endmodule

// File: tb/ea_gen_tb_top.sv
`timescale 1ns/1ps
module ea_gen_tb_top;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         start = 1'b0, addr32 = 1'b0, byte_valid = 1'b0;
  logic [7:0]   modrm = '0, byte_data = '0;
  logic [255:0] regs;
  logic         byte_ready, done, stack_dflt, is_reg;
  logic [31:0]  ea;
  logic [2:0]   reg_sel, length;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ea_gen dut_i (.clk(clk), .rst_n(rst_n), .start(start), .addr32(addr32), .modrm(modrm),
    .regs(regs), .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
    .done(done), .ea(ea), .stack_dflt(stack_dflt), .is_reg(is_reg), .reg_sel(reg_sel),
    .length(length));

  assign regs = {32'h000000FF, 32'h55550014, 32'h12348000, 32'h00007FF0,
                 32'hABCDF000, 32'h00000300, 32'h00000020, 32'h00001000};

  // {addr32, modrm, stream bytes (first in [7:0]), ea, stack, is_reg, sel, len}
  localparam int NV = 16;
  localparam logic [96:0] TBL [0:NV-1] = '{
    {1'b0, 8'h00, 48'h0,            32'h0000F014, 1'b0, 1'b0, 3'd0, 3'd1},
    {1'b0, 8'h02, 48'h0,            32'h00008014, 1'b1, 1'b0, 3'd0, 3'd1},
    {1'b0, 8'h06, 48'h1234,         32'h00001234, 1'b0, 1'b0, 3'd0, 3'd3},
    {1'b0, 8'h46, 48'h80,           32'h00007F80, 1'b1, 1'b0, 3'd0, 3'd2},
    {1'b0, 8'h47, 48'h7F,           32'h0000F07F, 1'b0, 1'b0, 3'd0, 3'd2},
    {1'b0, 8'h81, 48'h1001,         32'h00000100, 1'b0, 1'b0, 3'd0, 3'd3},
    {1'b0, 8'hC5, 48'h0,            32'h00000000, 1'b0, 1'b1, 3'd5, 3'd1},
    {1'b1, 8'h05, 48'h12345678,     32'h12345678, 1'b0, 1'b0, 3'd0, 3'd5},
    {1'b1, 8'h45, 48'hFF,           32'h12347FFF, 1'b1, 1'b0, 3'd0, 3'd2},
    {1'b1, 8'h04, 48'h88,           32'h00001080, 1'b0, 1'b0, 3'd0, 3'd2},
    {1'b1, 8'h04, 48'h0000010000E5, 32'h00010000, 1'b0, 1'b0, 3'd0, 3'd6},
    {1'b1, 8'h44, 48'hF024,         32'h00007FE0, 1'b1, 1'b0, 3'd0, 3'd3},
    {1'b1, 8'h84, 48'h00000000017D, 32'h123481FF, 1'b1, 1'b0, 3'd0, 3'd6},
    {1'b1, 8'h83, 48'h000010000000, 32'hBBCDF000, 1'b0, 1'b0, 3'd0, 3'd5},
    {1'b1, 8'h00, 48'h0,            32'h00001000, 1'b0, 1'b0, 3'd0, 3'd1},
    {1'b0, 8'h86, 48'h0010,         32'h00008010, 1'b1, 1'b0, 3'd0, 3'd3}
  };
  string tag [0:NV-1] = '{"R2", "R4", "R3", "R4", "R3", "R3", "R1", "R5",
                          "R5", "R6", "R7", "R7", "R7", "R5", "R5", "R11"};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input int k, input int gap, input bit intrude);
    logic [96:0] v;
    int nb;
    v = TBL[k];
    nb = v[6] ? 0 : int'(v[2:0]) - 1;
    @(negedge clk);
    addr32 = v[96]; modrm = v[95:88]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < nb; i++) begin
      repeat (gap) @(negedge clk);
      chk(done == 1'b0, "R9", "done before last byte", {31'd0, done}, 32'd0);
      chk(byte_ready == 1'b1, "R8", "ready while byte owed", {31'd0, byte_ready}, 32'd1);
      byte_valid = 1'b1;
      byte_data  = v[40 + 8*i +: 8];
      if (intrude && i == 1) begin
        start = 1'b1; modrm = 8'hC3; addr32 = ~v[96];
      end
      @(negedge clk);
      byte_valid = 1'b0; start = 1'b0;
    end
    chk(done == 1'b1, tag[k], "done", {31'd0, done}, 32'd1);
    chk(ea == v[39:8], tag[k], "ea", ea, v[39:8]);
    chk(stack_dflt == v[7], tag[k], "stack_dflt", {31'd0, stack_dflt}, {31'd0, v[7]});
    chk(is_reg == v[6], "R1", "is_reg", {31'd0, is_reg}, {31'd0, v[6]});
    if (v[6]) chk(reg_sel == v[5:3], "R1", "reg_sel", {29'd0, reg_sel}, {29'd0, v[5:3]});
    chk(length == v[2:0], "R10", "length", {29'd0, length}, {29'd0, v[2:0]});
    @(negedge clk);
    chk(done == 1'b0, "R9", "done pulse width", {31'd0, done}, 32'd0);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R9", "reset done", {31'd0, done}, 32'd0);
    chk(byte_ready == 1'b0, "R8", "reset ready", {31'd0, byte_ready}, 32'd0);
    rst_n = 1'b1;
    for (int k = 0; k < NV - 1; k++) run_vec(k, 0, 1'b0);
    // R8: stalls between bytes
    run_vec(12, 2, 1'b0);
    run_vec(7, 1, 1'b0);
    // R11: start while busy is ignored
    run_vec(15, 0, 1'b1);
    // R11: byte_valid while idle is ignored
    @(negedge clk);
    byte_valid = 1'b1; byte_data = 8'hAA;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk(byte_ready == 1'b0 && done == 1'b0, "R11", "idle valid ignored",
          {30'd0, byte_ready, done}, 32'd0);
    end
    byte_valid = 1'b0;
    run_vec(2, 0, 1'b0);
    run_vec(10, 0, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule